// File: doc/BRIEF.md
# Count/Limit Interval Timer

This block is a free-running interval timer that a processor core programs through a small register port. A 32-bit counter climbs by one on every cycle in which the tick input is high. When a tick finds the counter equal to the limit register, the timer expires: the counter restarts from zero and the pending flag in the control register is set. If the enable flag is set and the pending flag was still clear before that expiry, the interrupt line is raised. Software acknowledges by writing the control register with the pending bit cleared, which lowers the line.

The interrupt line is held by a two-state machine. `IRQ_QUIET` is the reset state with the line low. The RAISE transition (an expiry with enable set and pending clear) moves it to `IRQ_ASSERTED`, which drives the line high. The ACK transition (a control write that takes pending from 1 to 0) returns it to `IRQ_QUIET`. Any other input keeps the current state.

Register map on `reg_addr`: 0 is the count, 1 is the control register, 2 is the limit, and 3 is unused (it reads zero and ignores writes). In the control register, bit 0 enables the interrupt, bit 3 is the pending flag, and bits 1, 2 and 4 are plain storage. Reads are combinational. Writes take effect at the clock edge. A build with `TIMER_PRESENT = 0` leaves every register at its reset value.

Top module: `count_limit_timer`

## Requirements
- R1: After reset the count is 0, the control register is 0, the limit is 0x00FFFFFF and `irq_o` is low.
- R2: In a cycle with `tick_en` high, no write, and the count not equal to the limit, the count increases by exactly one at the next edge. With `tick_en` low the count holds.
- R3: A tick that finds the count equal to the limit makes the count 0 and sets control bit 3 (pending) at the next edge.
- R4: `irq_o` rises at the edge of an expiry only if control bit 0 (enable) is 1 and bit 3 (pending) was 0 before it. An expiry with pending already set, or with enable clear, leaves `irq_o` unchanged.
- R5: A control write stores only `reg_wdata[4:0]`. Reading address 1 returns those 5 bits with bits 31:5 zero.
- R6: A control write with `reg_wdata[3]` = 0 while pending is 1 lowers `irq_o` at the next edge. Control writes that keep pending set, and writes to other addresses, leave `irq_o` unchanged.
- R7: A write to address 0 loads the count at the next edge, and later ticks continue counting up from the loaded value.
- R8: If the limit is below the count, the counter runs through 0xFFFFFFFF to 0 with no expiry and expires when it next equals the limit.
- R9: A cycle with `reg_wr` high, at any address, suspends counting and expiry for that cycle.
- R10: With `TIMER_PRESENT = 0`, writes and ticks are ignored and every register reads its reset value.
- R11: Address 0 reads the count, 1 the control register, 2 the limit, and 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable tick for this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Timer interrupt line |

## Verification
Every write and every tick becomes visible one clock edge after it is presented. This covers the register read-back, the counter wrap, the setting of the pending flag, and the rising or falling of `irq_o`. Read data is combinational, so it follows `reg_addr` within the same cycle. The bench drives inputs one nanosecond after an edge, updates its reference model for that edge, and compares `irq_o` and the addressed register shortly after the next edge. Each result is therefore compared in the first cycle in which it is due, never earlier or later.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        ADDR_COUNT = 2'd0,
        ADDR_CTRL  = 2'd1,
        ADDR_LIMIT = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;

    localparam int CTRL_IE = 0;
    localparam int CTRL_IP = 3;

    typedef enum logic {
        IRQ_QUIET    = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_go,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] count,
    output logic              expire
);
    always_comb begin
        expire = tick_go && (count == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (expire) begin
            count <= '0;
        end else if (tick_go) begin
            count <= count + 1'b1;
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !load |=> count == '0); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_go && !expire && !load |=> count == DATA_W'($past(count) + 1'b1)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_go && !load |=> $stable(count)); // R9
endmodule

// File: rtl/timer_ctrl_regs.sv
module timer_ctrl_regs
    import timer_pkg::*;
#(
    parameter int              DATA_W      = 32,
    parameter int              CTRL_W      = 5,
    parameter logic [DATA_W-1:0] LIMIT_RESET = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_limit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] limit,
    output logic              ack,
    output logic              raise
);
    logic pend;
    logic ien;

    always_comb begin
        pend  = ctrl[CTRL_IP];
        ien   = ctrl[CTRL_IE];
        ack   = wr_ctrl && pend && !wdata[CTRL_IP];
        raise = expire && ien && !pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= wdata[CTRL_W-1:0];
        end else if (expire) begin
            ctrl[CTRL_IP] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= LIMIT_RESET;
        end else if (wr_limit) begin
            limit <= wdata;
        end
    end

    AST_PEND_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !wr_ctrl |=> ctrl[CTRL_IP]); // R3
    AST_LIMIT_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_limit |=> $stable(limit)); // R11
endmodule

// File: rtl/timer_irq_fsm.sv
module timer_irq_fsm
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:    if (raise) state_d = IRQ_ASSERTED;
            IRQ_ASSERTED: if (ack)   state_d = IRQ_QUIET;
            default:      state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_ASSERTED);
    end

    AST_RAISE_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(raise && ack)); // R9
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq); // R6
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(raise)); // R4
endmodule

// File: rtl/count_limit_timer.sv
module count_limit_timer
    import timer_pkg::*;
#(
    parameter int                DATA_W        = 32,
    parameter int                CTRL_W        = 5,
    parameter logic [DATA_W-1:0] LIMIT_RESET   = 32'h00FF_FFFF,
    parameter bit                TIMER_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - CTRL_W;

    logic              wr_en;
    logic              tick_go;
    logic              wr_count;
    logic              wr_ctrl;
    logic              wr_limit;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] limit;
    logic [CTRL_W-1:0] ctrl;
    logic              expire;
    logic              ack;
    logic              raise;
    reg_addr_e         sel;

    generate
        if (TIMER_PRESENT) begin : g_fitted
            assign wr_en   = reg_wr;
            assign tick_go = tick_en && !reg_wr;
        end else begin : g_absent
            assign wr_en   = 1'b0;
            assign tick_go = 1'b0;
        end
    endgenerate

    always_comb begin
        sel      = reg_addr_e'(reg_addr);
        wr_count = wr_en && (sel == ADDR_COUNT);
        wr_ctrl  = wr_en && (sel == ADDR_CTRL);
        wr_limit = wr_en && (sel == ADDR_LIMIT);
    end

    timer_counter #(.DATA_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_go  (tick_go),
        .load     (wr_count),
        .load_val (reg_wdata),
        .limit    (limit),
        .count    (count),
        .expire   (expire)
    );

    timer_ctrl_regs #(
        .DATA_W      (DATA_W),
        .CTRL_W      (CTRL_W),
        .LIMIT_RESET (LIMIT_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_limit (wr_limit),
        .wdata    (reg_wdata),
        .expire   (expire),
        .ctrl     (ctrl),
        .limit    (limit),
        .ack      (ack),
        .raise    (raise)
    );

    timer_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise),
        .ack   (ack),
        .irq   (irq_o)
    );

    always_comb begin
        unique case (sel)
            ADDR_COUNT: reg_rdata = count;
            ADDR_CTRL:  reg_rdata = {{PAD_W{1'b0}}, ctrl};
            ADDR_LIMIT: reg_rdata = limit;
            default:    reg_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl[CTRL_IP]); // R4
    AST_NO_WRITE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> $stable(ctrl) || $past(wr_ctrl)); // R10
endmodule

// File: tb/count_limit_timer_test.sv
`timescale 1ns/1ps
module count_limit_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic [31:0] ab_rdata;
    logic        ab_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_cnt;
    logic [4:0]  m_ctl;
    logic [31:0] m_lim;
    logic        m_irq;

    always #2 clk = ~clk;

    count_limit_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    count_limit_timer #(.TIMER_PRESENT(1'b0)) uut_absent (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(ab_rdata), .irq_o(ab_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return {27'b0, m_ctl};
            2'd2:    return m_lim;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] absent_reg(input logic [1:0] a);
        return (a == 2'd2) ? 32'h00FF_FFFF : 32'h0;
    endfunction

    task automatic model_step(input logic tk, input logic wr, input logic [1:0] a,
                              input logic [31:0] d);
        if (wr) begin
            case (a)
                2'd0: m_cnt = d;
                2'd1: begin
                    if (m_ctl[3] && !d[3]) m_irq = 1'b0;
                    m_ctl = d[4:0];
                end
                2'd2: m_lim = d;
                default: ;
            endcase
        end else if (tk) begin
            if (m_cnt == m_lim) begin
                if (m_ctl[0] && !m_ctl[3]) m_irq = 1'b1;
                m_ctl[3] = 1'b1;
                m_cnt = '0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    task automatic step(input logic tk, input logic wr, input logic [1:0] a,
                        input logic [31:0] d);
        tick_en = tk; reg_wr = wr; reg_addr = a; reg_wdata = d;
        model_step(tk, wr, a, d);
        @(posedge clk); #1;
        tick_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        reg_addr = a; #0.1;
        chk(tag, reg_rdata, exp_reg(a));
        chk("R10 absent build", ab_rdata, absent_reg(a));
    endtask

    task automatic irq_chk(input string tag);
        chk(tag, {31'b0, irq_o}, {31'b0, m_irq});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1207));
        m_cnt = '0; m_ctl = '0; m_lim = 32'h00FF_FFFF; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R11 reset values and map
        reg_addr = 2'd0; #0.1; chk("R1 count", reg_rdata, 32'h0);
        reg_addr = 2'd1; #0.1; chk("R1 ctrl", reg_rdata, 32'h0);
        reg_addr = 2'd2; #0.1; chk("R1 limit", reg_rdata, 32'h00FF_FFFF);
        reg_addr = 2'd3; #0.1; chk("R11 spare", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 counting and holding
        ticks(5);
        reg_addr = 2'd0; #0.1; chk("R2 five ticks", reg_rdata, 32'd5);
        step(1'b0, 1'b0, 2'd0, '0); step(1'b0, 1'b0, 2'd0, '0);
        rd(2'd0, "R2 hold");

        // R7 load then continue
        step(1'b0, 1'b1, 2'd0, 32'd100);
        rd(2'd0, "R7 load");
        ticks(3);
        reg_addr = 2'd0; #0.1; chk("R7 continue", reg_rdata, 32'd103);

        // R9 write suspends tick
        step(1'b1, 1'b1, 2'd2, 32'd105);
        rd(2'd0, "R9 suspended tick");
        step(1'b1, 1'b1, 2'd1, 32'h1);
        rd(2'd0, "R9 suspended tick ctrl");
        ticks(2);
        irq_chk("R4 before expiry");
        ticks(1);
        rd(2'd0, "R3 wrap");
        rd(2'd1, "R3 pending");
        irq_chk("R4 raised");
        chk("R4 raised literal", {31'b0, irq_o}, 32'h1);

        // R6 non-ack writes keep the line
        step(1'b0, 1'b1, 2'd1, 32'h19);
        irq_chk("R6 pending kept");
        step(1'b0, 1'b1, 2'd0, 32'd50);
        irq_chk("R6 count write");
        step(1'b0, 1'b1, 2'd1, 32'h1);
        irq_chk("R6 ack");
        chk("R6 ack literal", {31'b0, irq_o}, 32'h0);

        // R4 no raise when pending already set
        step(1'b0, 1'b1, 2'd1, 32'h9);
        step(1'b0, 1'b1, 2'd2, 32'd52);
        ticks(3);
        irq_chk("R4 pending already set");
        rd(2'd0, "R3 second wrap");
        // R4 no raise when enable clear
        step(1'b0, 1'b1, 2'd1, 32'h0);
        step(1'b0, 1'b1, 2'd0, 32'd52);
        ticks(1);
        irq_chk("R4 enable clear");
        rd(2'd1, "R3 pending without enable");

        // R5 control mask
        step(1'b0, 1'b1, 2'd1, 32'hFFFF_FFF6);
        rd(2'd1, "R5 mask");

        // R8 limit below count wraps through all ones
        step(1'b0, 1'b1, 2'd1, 32'h1);
        step(1'b0, 1'b1, 2'd2, 32'd3);
        step(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFE);
        ticks(2);
        rd(2'd0, "R8 through zero");
        rd(2'd1, "R8 no expiry on wrap");
        irq_chk("R8 no irq on wrap");
        ticks(4);
        rd(2'd0, "R8 expired at limit");
        irq_chk("R8 irq at limit");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [1:0] a;
            logic [31:0] d;
            r = $urandom % 100;
            a = 2'($urandom % 4);
            case (a)
                2'd2:    d = $urandom % 12;
                2'd0:    d = $urandom % 12;
                default: d = $urandom;
            endcase
            if (r < 12) step(1'b1, 1'b1, a, d);
            else if (r < 80) step(1'b1, 1'b0, 2'd0, '0);
            else step(1'b0, 1'b0, 2'd0, '0);
            irq_chk("R4 random irq");
            rd(2'($urandom % 4), "R2 random readback");
        end
        chk("R10 absent irq", {31'b0, ab_irq}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule